// File: doc/BRIEF.md
# Packet-Committing Drop-on-Overflow Buffer

This block sits between a source that cannot be paused, such as a line receiver that delivers one beat per cycle whenever it has data, and a consumer that wants a normal valid/ready stream. Incoming beats are stored in a circular buffer as a packet is received. They become readable only once the beat that carries the end-of-packet flag has been stored. That final beat is the commit that publishes the whole packet to the read side.

Two write pointers are kept. The speculative pointer advances with every stored beat. The committed pointer moves only when a packet completes. If a beat arrives while the buffer is full, or the abort input is raised, the speculative pointer is rewound to the committed pointer. The partial packet is then gone as a unit, and the block emits a one-cycle drop pulse. After an overflow, the remaining beats of that packet are discarded up to its end flag, so the next packet begins cleanly. Every stored entry carries its end flag, so packet boundaries survive on the output side.

The write side is a two-state machine. In FILL, beats are stored. Three transitions leave or act on FILL:
- FILL→SKIP happens on an overflow that hits a beat without the end flag.
- FILL→FILL with a rewind happens on an abort, or on an overflow that hits a beat with the end flag.
- FILL→FILL with a commit happens on a stored end beat.

In SKIP, beats are discarded. SKIP→FILL happens on a beat with the end flag or on an abort, and neither produces another pulse.

Top module: `pkt_drop_fifo`

## Requirements
- R1: After reset, `out_valid` and `drop_pulse` are 0.
- R2: Beats of a packet are not visible at the output until its end-flag beat is stored. `out_valid` rises in the cycle after the clock edge that stores that beat.
- R3: Committed beats leave the output in arrival order, with their data and with `out_last`=1 exactly on each packet's final beat.
- R4: While `out_valid`=1 and `out_ready`=0, the output holds `out_valid`, `out_data` and `out_last` unchanged into the next cycle.
- R5: A beat that arrives in FILL while the buffer holds DEPTH entries (counting committed and speculative entries) discards the whole partial packet. `drop_pulse` is then 1 for exactly one cycle, in the cycle after that beat.
- R6: After an overflow on a beat without the end flag, the machine is in SKIP. Every further beat up to and including the next end-flag beat is ignored, even if space has been freed. The packet after that is stored normally.
- R7: `in_abort`=1 in FILL rewinds to the last commit point, discards any beat presented in the same cycle, and pulses `drop_pulse` once.
- R8: `in_abort`=1 in SKIP returns to FILL without a further `drop_pulse`.
- R9: A packet of exactly DEPTH beats is kept when the buffer is empty.
- R10: Packets committed before a drop are delivered intact after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming beat present (no back-pressure) |
| in_data | input | DATA_W | Incoming beat data |
| in_last | input | 1 | Incoming beat ends its packet |
| in_abort | input | 1 | Discard the packet in progress |
| out_valid | output | 1 | Committed beat available |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | DATA_W | Outgoing beat data |
| out_last | output | 1 | Outgoing beat ends its packet |
| drop_pulse | output | 1 | One-cycle pulse per discarded packet |

## Verification
The assertions take for granted that inputs are free of X once reset is released. They also assume the consumer does not depend on `out_data` when `out_valid` is 0. The stimulus drives every input one nanosecond after the rising edge and holds it steady through the next edge. Outside the phase with a randomised ready line, it keeps `out_ready` low whenever a test depends on exact buffer occupancy. The bench's drop decision therefore follows from the number of entries still queued for output. Abort is raised only in cycles where `in_valid` is low, apart from the cases the requirements name.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
    typedef enum logic {
        WR_FILL = 1'b0,
        WR_SKIP = 1'b1
    } wr_state_e;
endpackage

// File: rtl/pkt_fifo_store.sv
module pkt_fifo_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int ENT_W = DATA_W + 1;

    logic [ENT_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= {wr_last, wr_data};
        end
    end

    always_comb begin
        {rd_last, rd_data} = cells[rd_addr];
    end
endmodule

// File: rtl/pkt_fifo_wr_ctrl.sv
module pkt_fifo_wr_ctrl
    import pkt_fifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              in_abort,
    input  logic [ADDR_W:0]   rd_ptr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   commit_ptr,
    output logic              drop_pulse
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    wr_state_e        state_q, state_d;
    logic [PTR_W-1:0] spec_q, spec_d;
    logic [PTR_W-1:0] commit_q, commit_d;
    logic             drop_q, drop_d;
    logic [PTR_W-1:0] occ;
    logic             full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WR_FILL;
            spec_q   <= '0;
            commit_q <= '0;
            drop_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            spec_q   <= spec_d;
            commit_q <= commit_d;
            drop_q   <= drop_d;
        end
    end

    always_comb begin
        occ      = spec_q - rd_ptr;
        full     = (occ == DEPTH_P);
        state_d  = state_q;
        spec_d   = spec_q;
        commit_d = commit_q;
        drop_d   = 1'b0;
        wr_en    = 1'b0;
        unique case (state_q)
            WR_FILL: begin
                if (in_abort) begin
                    spec_d = commit_q;
                    drop_d = 1'b1;
                end else if (in_valid) begin
                    if (full) begin
                        spec_d = commit_q;
                        drop_d = 1'b1;
                        if (!in_last) begin
                            state_d = WR_SKIP;
                        end
                    end else begin
                        wr_en  = 1'b1;
                        spec_d = spec_q + 1'b1;
                        if (in_last) begin
                            commit_d = spec_q + 1'b1;
                        end
                    end
                end
            end
            WR_SKIP: begin
                if (in_abort || (in_valid && in_last)) begin
                    state_d = WR_FILL;
                end
            end
            default: state_d = WR_FILL;
        endcase
    end

    assign wr_addr    = spec_q[ADDR_W-1:0];
    assign commit_ptr = commit_q;
    assign drop_pulse = drop_q;

    p_occ_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_P);
    p_drop_rewound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drop_q |-> (spec_q == commit_q));
    p_skip_holds_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WR_SKIP) |=> $stable(commit_q));
    p_commit_needs_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_last) |=> $stable(commit_q));
    p_abort_pulses_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_abort && state_q == WR_FILL) |=> drop_q);
    p_skip_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_abort && state_q == WR_SKIP) |=> (!drop_q && state_q == WR_FILL));
endmodule

// File: rtl/pkt_fifo_rd_ctrl.sv
module pkt_fifo_rd_ctrl #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W:0]   commit_ptr,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [ADDR_W:0]   rd_ptr,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    logic [PTR_W-1:0] rd_q;
    logic [PTR_W-1:0] avail;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (out_valid && out_ready) begin
            rd_q <= rd_q + 1'b1;
        end
    end

    always_comb begin
        avail     = commit_ptr - rd_q;
        out_valid = (avail != '0);
    end

    assign rd_ptr  = rd_q;
    assign rd_addr = rd_q[ADDR_W-1:0];

    p_avail_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        avail <= DEPTH_P);
    p_stall_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(rd_q)));
endmodule

// File: rtl/pkt_drop_fifo.sv
module pkt_drop_fifo #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_abort,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              drop_pulse
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W:0]   commit_ptr;
    logic [ADDR_W:0]   rd_ptr;
    logic [ADDR_W-1:0] rd_addr;

    pkt_fifo_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_abort   (in_abort),
        .rd_ptr     (rd_ptr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .commit_ptr (commit_ptr),
        .drop_pulse (drop_pulse)
    );

    pkt_fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (in_data),
        .wr_last (in_last),
        .rd_addr (rd_addr),
        .rd_data (out_data),
        .rd_last (out_last)
    );

    pkt_fifo_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_ptr (commit_ptr),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .rd_ptr     (rd_ptr),
        .rd_addr    (rd_addr)
    );

    p_stall_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_last)));
    p_drop_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |=> !drop_pulse || $past(in_abort || in_valid));
endmodule

// File: tb/pkt_drop_fifo_bench.sv
module pkt_drop_fifo_bench;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_last = 1'b0;
    logic              in_abort = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [DATA_W-1:0] out_data;
    logic              out_last;
    logic              drop_pulse;

    int checks = 0;
    int fails = 0;
    int seen_drops = 0;
    int exp_drops = 0;
    bit toggle_en = 1'b0;
    bit done = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    logic [DATA_W:0] exp_q [$];
    bit prev_stall = 1'b0;
    logic [DATA_W:0] prev_out = '0;

    always #4 clk = ~clk;

    pkt_drop_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pkt_drop_fifo (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_abort(in_abort), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .drop_pulse(drop_pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (drop_pulse) seen_drops++;
            if (prev_stall) begin
                check(out_valid && {out_last, out_data} == prev_out, "R4 stall hold",
                      int'({out_last, out_data}), int'(prev_out));
            end
            prev_stall = out_valid && !out_ready;
            prev_out   = {out_last, out_data};
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected beat", int'({out_last, out_data}), -1);
                end else begin
                    logic [DATA_W:0] e;
                    e = exp_q.pop_front();
                    check({out_last, out_data} == e, "R3 data/last order",
                          int'({out_last, out_data}), int'(e));
                end
            end
        end
    end

    always @(posedge clk) begin
        if (toggle_en) begin
            #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = lfsr[0];
        end
    end

    task automatic beat(input logic [DATA_W-1:0] d, input bit last, input bit abort_v, input bit vld);
        @(posedge clk); #1;
        in_valid = vld; in_data = d; in_last = last; in_abort = abort_v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0; in_last = 1'b0; in_abort = 1'b0;
        end
    endtask

    task automatic send_pkt(input int len, input int base, input bit keep);
        for (int i = 0; i < len; i++) begin
            logic [DATA_W-1:0] d;
            d = DATA_W'(base + i);
            beat(d, i == len - 1, 1'b0, 1'b1);
            if (keep) exp_q.push_back({i == len - 1, d});
        end
        idle(1);
    endtask

    task automatic drain();
        out_ready = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(!out_valid, "R10 empty after drain", out_valid, 0);
        out_ready = 1'b0;
    endtask

    task automatic check_drops(input string tag);
        @(negedge clk);
        check(seen_drops == exp_drops, tag, seen_drops, exp_drops);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R1 out_valid after reset", out_valid, 0);
        check(!drop_pulse, "R1 drop_pulse after reset", drop_pulse, 0);

        // R2: invisibility before commit
        for (int i = 0; i < 3; i++) begin
            beat(DATA_W'(8'h10 + i), 1'b0, 1'b0, 1'b1);
            exp_q.push_back({1'b0, DATA_W'(8'h10 + i)});
            @(negedge clk);
            check(!out_valid, "R2 partial hidden", out_valid, 0);
        end
        beat(8'h13, 1'b1, 1'b0, 1'b1);
        exp_q.push_back({1'b1, 8'h13});
        @(negedge clk);
        check(!out_valid, "R2 not before store edge", out_valid, 0);
        idle(1);
        @(negedge clk);
        check(out_valid, "R2 visible after commit", out_valid, 1);
        drain();

        // R3/R4: mixed lengths with random ready
        toggle_en = 1'b1;
        send_pkt(1, 8'h20, 1'b1);
        send_pkt(2, 8'h30, 1'b1);
        send_pkt(5, 8'h40, 1'b1);
        send_pkt(3, 8'h50, 1'b1);
        repeat (60) @(posedge clk);
        toggle_en = 1'b0;
        #2;
        drain();
        check_drops("R3 no drops for small packets");

        // R9: exactly DEPTH beats
        send_pkt(DEPTH, 8'h60, 1'b1);
        check_drops("R9 full-size packet kept");
        drain();

        // R5/R6/R10: overflow mid-packet, skip remainder
        send_pkt(10, 8'h80, 1'b1);
        send_pkt(10, 8'h90, 1'b0);
        exp_drops++;
        send_pkt(3, 8'hA0, 1'b1);
        check_drops("R5 one drop pulse");
        drain();

        // R5: overflow hitting the end beat
        send_pkt(13, 8'hB0, 1'b1);
        send_pkt(4, 8'hC0, 1'b0);
        exp_drops++;
        send_pkt(3, 8'hD0, 1'b1);
        check_drops("R5 drop on end beat");
        drain();

        // R7: abort in FILL
        for (int i = 0; i < 3; i++) beat(DATA_W'(8'hE0 + i), 1'b0, 1'b0, 1'b1);
        beat(8'h00, 1'b0, 1'b1, 1'b0);
        exp_drops++;
        idle(2);
        @(negedge clk);
        check(!out_valid, "R7 aborted data hidden", out_valid, 0);
        check_drops("R7 abort pulse");
        send_pkt(2, 8'hE8, 1'b1);
        drain();

        // R8: abort while skipping
        send_pkt(DEPTH, 8'h40, 1'b1);
        beat(8'hF0, 1'b0, 1'b0, 1'b1);
        exp_drops++;
        beat(8'hF1, 1'b0, 1'b0, 1'b1);
        beat(8'h00, 1'b0, 1'b1, 1'b0);
        idle(2);
        check_drops("R8 no pulse for abort in SKIP");
        drain();
        send_pkt(2, 8'hF8, 1'b1);
        drain();
        check_drops("R8 final drop count");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule